// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block runs whole register transactions on an I2C bus by driving a byte-level master engine, one step at a time. A caller pulses a start input together with an operation (read or write), a 7-bit slave address, an 8-bit register pointer, a length flag and, for writes, one data byte. The sequencer then issues each START, address byte, pointer byte, data byte, receive request and STOP in turn. Before each next step it waits for the engine event that confirms the previous one.

A read is done in two phases. The first phase sets the slave's register pointer. It sends START, the address with the direction bit clear and the pointer, then waits until that byte has fully gone out. The second phase sends a repeated START and the address with the direction bit set, then receives one or two bytes. Every received byte except the last is acknowledged. STOP goes out once the final byte has been captured. The result is returned with the first byte in the low half. A write sends the address, the pointer and one data byte, then STOP.

Each wait is bounded by a cycle limit. A timeout or a slave NACK makes the sequencer issue STOP and finish with an error flag.

Top module: `i2cRegSeq`

## Requirements
- R1: A write issues, in order: START; the byte {slave, 0}; the pointer byte; the data byte; then STOP. It finishes with `err`=0 and `rdData`=0.
- R2: The first START of a transaction is requested only in a cycle after `engBusy` was seen low.
- R3: A read issues START, {slave, 0} and the pointer, and waits for `engTxDoneEv`. It then issues a second START and the byte {slave, 1}.
- R4: A one-byte read (`cmdTwo`=0) makes a single receive request with `engRxAck`=0. It returns `rdData` = {8'h00, byte}.
- R5: A two-byte read makes two receive requests, the first with `engRxAck`=1 and the second with `engRxAck`=0. It returns `rdData` = {second byte, first byte}.
- R6: STOP is requested only after the last awaited engine event (for a read, the final received byte). `done` pulses for one cycle, in the cycle right after the STOP request.
- R7: A NACK while the sequencer waits for an address or data acknowledge leads to STOP and then `done` with `err`=1. No further byte is sent. `err` is never high without `done`.
- R8: A wait longer than `TimeoutCycles` cycles, including the wait for the bus to go idle, leads to STOP and then `done` with `err`=1. An awaited event that arrives in the last allowed cycle is accepted and the transaction goes on.
- R9: A `cmdStart` pulse while a transaction is running has no effect. The running transaction completes unchanged and `done` pulses once.
- R10: At most one engine request (START, STOP, byte send, byte receive) is raised in any cycle. After reset no request is raised and `done`, `err` and `rdData` are 0.
- R11: In a write, the data byte is sent once `engTxEmptyEv` follows the pointer byte, without waiting for `engTxDoneEv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | One-cycle pulse that starts a transaction when the sequencer is idle |
| cmdRead | input | 1 | 1 = register read, 0 = register write |
| cmdTwo | input | 1 | Read length: 1 = two bytes, 0 = one byte |
| cmdSlave | input | 7 | Slave address |
| cmdReg | input | 8 | Register pointer |
| cmdWrData | input | 8 | Data byte for a write |
| engBusy | input | 1 | Bus is busy |
| engStartEv | input | 1 | START or repeated START has been placed on the bus |
| engAddrAckEv | input | 1 | Address byte was acknowledged |
| engTxEmptyEv | input | 1 | Engine holding register is free for the next byte |
| engTxDoneEv | input | 1 | Last byte has been fully shifted out and acknowledged |
| engRxEv | input | 1 | A received byte is available on engRxData |
| engRxData | input | 8 | Received byte |
| engNack | input | 1 | Slave did not acknowledge a byte |
| engStartReq | output | 1 | Request a START (or repeated START) |
| engStopReq | output | 1 | Request a STOP |
| engTxReq | output | 1 | Send engTxData |
| engTxData | output | 8 | Byte to send |
| engRxReq | output | 1 | Receive one byte |
| engRxAck | output | 1 | Acknowledge decision for the requested byte (1 = ACK) |
| done | output | 1 | One-cycle pulse: transaction finished |
| err | output | 1 | High with done when the transaction ended on a NACK or a timeout |
| rdData | output | 16 | Read result, valid with done |

## Verification
The awaited engine event and the wait-limit expiry can land in the same cycle. The bench provokes this by setting its engine model's response latency to exactly the limit, so every event arrives in the final allowed cycle of its wait. In that case a complete two-byte read must still return the right data with no error. The same vector with one more cycle of latency must instead end with STOP and an error, having sent no byte after the first START.

// File: rtl/i2cSeqPkg.sv
package i2cSeqPkg;
  localparam int ByteW = 8;
  localparam int SlaveAddrW = 7;
  localparam int RxLanes = 2;

  typedef enum logic [4:0] {
    S_IDLE, S_WBUSY, S_START1, S_WSTART1, S_ADDRW, S_WADDRW, S_REG, S_WREG,
    S_DATA, S_WDATA, S_START2, S_WSTART2, S_ADDRR, S_WADDRR, S_RX1, S_WRX1,
    S_RX2, S_WRX2, S_STOP, S_FIN
  } seqState_e;

  typedef enum logic [1:0] {TX_ADDR_W, TX_REG, TX_DATA, TX_ADDR_R} txSel_e;

  typedef struct packed {
    logic latchCmd;
    txSel_e txSel;
    logic [RxLanes-1:0] capLane;
  } seqStrobe_t;
endpackage

// File: rtl/i2cSeqCtrl.sv
module i2cSeqCtrl
  import i2cSeqPkg::*;
#(
  parameter int TimeoutCycles = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       isRead,
  input  logic       isTwo,
  input  logic       engBusy,
  input  logic       engStartEv,
  input  logic       engAddrAckEv,
  input  logic       engTxEmptyEv,
  input  logic       engTxDoneEv,
  input  logic       engRxEv,
  input  logic       engNack,
  output seqStrobe_t strobe,
  output logic       engStartReq,
  output logic       engStopReq,
  output logic       engTxReq,
  output logic       engRxReq,
  output logic       engRxAck,
  output logic       done,
  output logic       err
);
  localparam int CntW = $clog2(TimeoutCycles + 1);

  seqState_e state, nextState;
  logic [CntW-1:0] waitCnt;
  logic errFlag, setErr, waiting, expired;

  assign waiting = state inside {S_WBUSY, S_WSTART1, S_WADDRW, S_WREG, S_WDATA,
                                 S_WSTART2, S_WADDRR, S_WRX1, S_WRX2};
  assign expired = waiting && (waitCnt == CntW'(TimeoutCycles - 1));

  always_comb begin
    nextState   = state;
    setErr      = 1'b0;
    strobe      = '0;
    engStartReq = 1'b0;
    engStopReq  = 1'b0;
    engTxReq    = 1'b0;
    engRxReq    = 1'b0;
    engRxAck    = 1'b0;
    done        = 1'b0;
    err         = 1'b0;
    unique case (state)
      S_IDLE: begin
        strobe.latchCmd = cmdStart;
        if (cmdStart) nextState = S_WBUSY;
      end
      S_WBUSY:   if (!engBusy) nextState = S_START1;
      S_START1:  begin engStartReq = 1'b1; nextState = S_WSTART1; end
      S_WSTART1: if (engStartEv) nextState = S_ADDRW;
      S_ADDRW: begin
        engTxReq = 1'b1; strobe.txSel = TX_ADDR_W; nextState = S_WADDRW;
      end
      S_WADDRW: begin
        if (engNack) begin nextState = S_STOP; setErr = 1'b1; end
        else if (engAddrAckEv) nextState = S_REG;
      end
      S_REG: begin
        engTxReq = 1'b1; strobe.txSel = TX_REG; nextState = S_WREG;
      end
      S_WREG: begin
        if (engNack) begin nextState = S_STOP; setErr = 1'b1; end
        else if (isRead && engTxDoneEv) nextState = S_START2;
        else if (!isRead && engTxEmptyEv) nextState = S_DATA;
      end
      S_DATA: begin
        engTxReq = 1'b1; strobe.txSel = TX_DATA; nextState = S_WDATA;
      end
      S_WDATA: begin
        if (engNack) begin nextState = S_STOP; setErr = 1'b1; end
        else if (engTxDoneEv) nextState = S_STOP;
      end
      S_START2:  begin engStartReq = 1'b1; nextState = S_WSTART2; end
      S_WSTART2: if (engStartEv) nextState = S_ADDRR;
      S_ADDRR: begin
        engTxReq = 1'b1; strobe.txSel = TX_ADDR_R; nextState = S_WADDRR;
      end
      S_WADDRR: begin
        if (engNack) begin nextState = S_STOP; setErr = 1'b1; end
        else if (engAddrAckEv) nextState = S_RX1;
      end
      S_RX1: begin
        engRxReq = 1'b1; engRxAck = isTwo; nextState = S_WRX1;
      end
      S_WRX1: begin
        if (engRxEv) begin
          strobe.capLane[0] = 1'b1;
          nextState = isTwo ? S_RX2 : S_STOP;
        end
      end
      S_RX2:  begin engRxReq = 1'b1; engRxAck = 1'b0; nextState = S_WRX2; end
      S_WRX2: begin
        if (engRxEv) begin
          strobe.capLane[RxLanes-1] = 1'b1;
          nextState = S_STOP;
        end
      end
      S_STOP: begin engStopReq = 1'b1; nextState = S_FIN; end
      S_FIN:  begin done = 1'b1; err = errFlag; nextState = S_IDLE; end
      default: nextState = S_IDLE;
    endcase
    // the awaited event has priority over expiry of the wait limit
    if (expired && nextState == state) begin
      nextState = S_STOP;
      setErr    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      errFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state) waitCnt <= '0;
      else if (waiting)       waitCnt <= waitCnt + 1'b1;
      if (strobe.latchCmd) errFlag <= 1'b0;
      else if (setErr)     errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/i2cSeqDpath.sv
module i2cSeqDpath
  import i2cSeqPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic                     cmdRead,
  input  logic                     cmdTwo,
  input  logic [SlaveAddrW-1:0]    cmdSlave,
  input  logic [ByteW-1:0]         cmdReg,
  input  logic [ByteW-1:0]         cmdWrData,
  input  logic [ByteW-1:0]         engRxData,
  output logic                     isRead,
  output logic                     isTwo,
  output logic [ByteW-1:0]         engTxData,
  output logic [RxLanes*ByteW-1:0] rdData
);
  logic [SlaveAddrW-1:0] slaveQ;
  logic [ByteW-1:0] regQ, wrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slaveQ <= '0; regQ <= '0; wrQ <= '0; isRead <= 1'b0; isTwo <= 1'b0;
    end else if (strobe.latchCmd) begin
      slaveQ <= cmdSlave; regQ <= cmdReg; wrQ <= cmdWrData;
      isRead <= cmdRead;  isTwo <= cmdTwo;
    end
  end

  for (genvar ln = 0; ln < RxLanes; ln++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN || strobe.latchCmd) rdData[ln*ByteW +: ByteW] <= '0;
      else if (strobe.capLane[ln])  rdData[ln*ByteW +: ByteW] <= engRxData;
    end
  end

  always_comb begin
    unique case (strobe.txSel)
      TX_ADDR_W: engTxData = {slaveQ, 1'b0};
      TX_ADDR_R: engTxData = {slaveQ, 1'b1};
      TX_REG:    engTxData = regQ;
      default:   engTxData = wrQ;
    endcase
  end
endmodule

// File: rtl/i2cRegSeq.sv
module i2cRegSeq
  import i2cSeqPkg::*;
#(
  parameter int TimeoutCycles = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStart,
  input  logic        cmdRead,
  input  logic        cmdTwo,
  input  logic [6:0]  cmdSlave,
  input  logic [7:0]  cmdReg,
  input  logic [7:0]  cmdWrData,
  input  logic        engBusy,
  input  logic        engStartEv,
  input  logic        engAddrAckEv,
  input  logic        engTxEmptyEv,
  input  logic        engTxDoneEv,
  input  logic        engRxEv,
  input  logic [7:0]  engRxData,
  input  logic        engNack,
  output logic        engStartReq,
  output logic        engStopReq,
  output logic        engTxReq,
  output logic [7:0]  engTxData,
  output logic        engRxReq,
  output logic        engRxAck,
  output logic        done,
  output logic        err,
  output logic [15:0] rdData
);
  seqStrobe_t strobe;
  logic isRead, isTwo;

  i2cSeqCtrl #(.TimeoutCycles(TimeoutCycles)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .isRead(isRead), .isTwo(isTwo),
    .engBusy(engBusy), .engStartEv(engStartEv), .engAddrAckEv(engAddrAckEv),
    .engTxEmptyEv(engTxEmptyEv), .engTxDoneEv(engTxDoneEv), .engRxEv(engRxEv),
    .engNack(engNack), .strobe(strobe), .engStartReq(engStartReq),
    .engStopReq(engStopReq), .engTxReq(engTxReq), .engRxReq(engRxReq),
    .engRxAck(engRxAck), .done(done), .err(err)
  );

  i2cSeqDpath i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdRead(cmdRead), .cmdTwo(cmdTwo),
    .cmdSlave(cmdSlave), .cmdReg(cmdReg), .cmdWrData(cmdWrData),
    .engRxData(engRxData), .isRead(isRead), .isTwo(isTwo),
    .engTxData(engTxData), .rdData(rdData)
  );
endmodule

// File: rtl/i2cRegSeqChk.sv
module i2cRegSeqChk (
  input logic clk,
  input logic rstN,
  input logic engStartReq,
  input logic engStopReq,
  input logic engTxReq,
  input logic engRxReq,
  input logic engRxAck,
  input logic engRxEv,
  input logic done,
  input logic err
);
  assert_one_request_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({engStartReq, engStopReq, engTxReq, engRxReq}));

  assert_err_only_with_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  assert_done_follows_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    engStopReq |=> done);

  assert_done_after_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(engStopReq));

  assert_second_byte_nacked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (engRxReq && $past(engRxEv)) |-> !engRxAck);
endmodule

bind i2cRegSeq i2cRegSeqChk u_chk (
  .clk(clk), .rstN(rstN), .engStartReq(engStartReq), .engStopReq(engStopReq),
  .engTxReq(engTxReq), .engRxReq(engRxReq), .engRxAck(engRxAck),
  .engRxEv(engRxEv), .done(done), .err(err)
);

// File: tb/test_i2cRegSeq.sv
module test_i2cRegSeq;
  localparam int ClkPeriod = 10;
  localparam int Tmo = 16;

  typedef struct packed {
    logic       rd;
    logic       two;
    logic [6:0] slv;
    logic [7:0] rg;
    logic [7:0] wd;
    logic [7:0] r0;
    logic [7:0] r1;
    logic [1:0] nk;   // tx index that is NACKed, 3 = none
    logic [5:0] dly;  // engine response latency in cycles
  } vec_t;

  localparam int NumVec = 9;
  localparam vec_t Vecs [0:NumVec-1] = '{
    '{1'b0, 1'b0, 7'h37, 8'h20, 8'hC7, 8'h00, 8'h00, 2'd3, 6'd2},
    '{1'b1, 1'b0, 7'h1D, 8'h28, 8'h00, 8'h39, 8'h00, 2'd3, 6'd3},
    '{1'b1, 1'b1, 7'h1D, 8'h2A, 8'h00, 8'h34, 8'h12, 2'd3, 6'd1},
    '{1'b1, 1'b1, 7'h55, 8'h00, 8'h00, 8'hFF, 8'h80, 2'd3, 6'd16},
    '{1'b0, 1'b0, 7'h7F, 8'hFF, 8'h00, 8'h00, 8'h00, 2'd0, 6'd2},
    '{1'b1, 1'b0, 7'h10, 8'h01, 8'h00, 8'h00, 8'h00, 2'd2, 6'd2},
    '{1'b0, 1'b0, 7'h22, 8'h33, 8'h44, 8'h00, 8'h00, 2'd2, 6'd2},
    '{1'b1, 1'b1, 7'h55, 8'h00, 8'h00, 8'hFF, 8'h80, 2'd3, 6'd17},
    '{1'b0, 1'b0, 7'h00, 8'h5A, 8'hA5, 8'h00, 8'h00, 2'd3, 6'd1}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdStart = 1'b0, cmdRead = 1'b0, cmdTwo = 1'b0;
  logic [6:0] cmdSlave = '0;
  logic [7:0] cmdReg = '0, cmdWrData = '0;
  logic engBusy = 1'b0;
  logic engStartEv = 1'b0, engAddrAckEv = 1'b0, engTxEmptyEv = 1'b0;
  logic engTxDoneEv = 1'b0, engRxEv = 1'b0, engNack = 1'b0;
  logic [7:0] engRxData = '0;
  logic engStartReq, engStopReq, engTxReq, engRxReq, engRxAck, done, err;
  logic [7:0] engTxData;
  logic [15:0] rdData;

  i2cRegSeq #(.TimeoutCycles(Tmo)) i_i2cRegSeq (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdRead(cmdRead),
    .cmdTwo(cmdTwo), .cmdSlave(cmdSlave), .cmdReg(cmdReg), .cmdWrData(cmdWrData),
    .engBusy(engBusy), .engStartEv(engStartEv), .engAddrAckEv(engAddrAckEv),
    .engTxEmptyEv(engTxEmptyEv), .engTxDoneEv(engTxDoneEv), .engRxEv(engRxEv),
    .engRxData(engRxData), .engNack(engNack), .engStartReq(engStartReq),
    .engStopReq(engStopReq), .engTxReq(engTxReq), .engTxData(engTxData),
    .engRxReq(engRxReq), .engRxAck(engRxAck), .done(done), .err(err),
    .rdData(rdData)
  );

  always #(ClkPeriod/2) clk = ~clk;

  int cyc = 0;
  int nChk = 0, nFail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // engine model configuration
  logic clrReq = 1'b0;
  logic curRd = 1'b0;
  logic [7:0] curR0 = '0, curR1 = '0;
  int curNk = 3, curDly = 1;

  // engine model log
  int nStart, nTx, nRx, nStop, nDone, firstStartCyc, stopCyc, lastRxCyc;
  logic [7:0] txLog [0:3];
  logic ackLog [0:1];
  int pend = 0, pendKind = 0;
  logic [7:0] pendByte = '0;

  always @(negedge clk) begin
    engStartEv = 1'b0; engAddrAckEv = 1'b0; engTxEmptyEv = 1'b0;
    engTxDoneEv = 1'b0; engRxEv = 1'b0; engNack = 1'b0;
    if (clrReq) begin
      nStart = 0; nTx = 0; nRx = 0; nStop = 0; nDone = 0;
      firstStartCyc = -1; stopCyc = -1; lastRxCyc = -1; pend = 0;
    end else begin
      if (pend > 0) begin
        pend = pend - 1;
        if (pend == 0) begin
          case (pendKind)
            0: engStartEv = 1'b1;
            1: engAddrAckEv = 1'b1;
            2: engTxEmptyEv = 1'b1;
            3: engTxDoneEv = 1'b1;
            4: begin engRxEv = 1'b1; engRxData = pendByte; lastRxCyc = cyc; end
            default: engNack = 1'b1;
          endcase
        end
      end
      if (done) nDone = nDone + 1;
      if (engStartReq) begin
        if (nStart == 0) firstStartCyc = cyc;
        nStart = nStart + 1; pend = curDly; pendKind = 0;
      end else if (engTxReq) begin
        if (nTx < 4) txLog[nTx] = engTxData;
        if (nTx == curNk)  pendKind = 5;
        else if (nTx == 1) pendKind = curRd ? 3 : 2;
        else if (nTx == 2) pendKind = curRd ? 1 : 3;
        else               pendKind = 1;
        nTx = nTx + 1; pend = curDly;
      end else if (engRxReq) begin
        if (nRx < 2) ackLog[nRx] = engRxAck;
        pendByte = (nRx == 0) ? curR0 : curR1;
        nRx = nRx + 1; pend = curDly; pendKind = 4;
      end else if (engStopReq) begin
        nStop = nStop + 1; stopCyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  logic gotErr;
  logic [15:0] gotData;
  bit gotDone;

  task automatic launch(input vec_t v);
    @(posedge clk); #1;
    clrReq = 1'b1; curRd = v.rd; curR0 = v.r0; curR1 = v.r1;
    curNk = int'(v.nk); curDly = int'(v.dly);
    @(posedge clk); #1;
    clrReq = 1'b0;
    cmdStart = 1'b1; cmdRead = v.rd; cmdTwo = v.two; cmdSlave = v.slv;
    cmdReg = v.rg; cmdWrData = v.wd;
    @(posedge clk); #1;
    cmdStart = 1'b0;
  endtask

  task automatic waitDone();
    gotDone = 1'b0;
    for (int i = 0; i < 600 && !gotDone; i++) begin
      @(negedge clk);
      if (done) begin gotDone = 1'b1; gotErr = err; gotData = rdData; end
    end
    chk(gotDone, "R6 done pulse seen", 32'(gotDone), 32'd1);
    repeat (Tmo + 8) @(negedge clk);
  endtask

  task automatic checkVec(input vec_t v);
    bit expErr, dataOk;
    int expTx, expStart, expRx;
    logic [15:0] expData;
    logic [7:0] expByte;
    expErr = (v.dly > 6'(Tmo)) || (v.nk != 2'd3);
    if (v.dly > 6'(Tmo)) begin expStart = 1; expTx = 0; expRx = 0; end
    else if (v.nk != 2'd3) begin
      expTx = int'(v.nk) + 1; expRx = 0;
      expStart = (v.rd && v.nk == 2'd2) ? 2 : 1;
    end else begin
      expTx = 3; expStart = v.rd ? 2 : 1; expRx = v.rd ? (v.two ? 2 : 1) : 0;
    end
    expData = !v.rd ? 16'h0 : (v.two ? {v.r1, v.r0} : {8'h00, v.r0});
    chk(gotErr == expErr, "R7 R8 err flag", 32'(gotErr), 32'(expErr));
    if (!expErr) begin
      dataOk = (gotData == expData);
      chk(dataOk, v.rd ? (v.two ? "R5 two-byte result" : "R4 one-byte result")
                       : "R1 write result zero", 32'(gotData), 32'(expData));
    end
    chk(nStart == expStart, "R3 START count", nStart, expStart);
    chk(nTx == expTx, "R1 R11 bytes sent", nTx, expTx);
    for (int i = 0; i < 3; i++) begin
      if (i < expTx && i < nTx) begin
        expByte = (i == 0) ? {v.slv, 1'b0} : (i == 1) ? v.rg
                : (v.rd ? {v.slv, 1'b1} : v.wd);
        chk(txLog[i] == expByte, "R1 R3 sent byte", 32'(txLog[i]), 32'(expByte));
      end
    end
    chk(nRx == expRx, "R4 R5 receive requests", nRx, expRx);
    if (expRx >= 1 && nRx >= 1)
      chk(ackLog[0] == (expRx == 2), "R4 R5 first ack decision",
          32'(ackLog[0]), 32'(expRx == 2));
    if (expRx == 2 && nRx == 2)
      chk(ackLog[1] == 1'b0, "R5 last byte NACKed", 32'(ackLog[1]), 32'd0);
    chk(nStop == 1, "R6 R7 R8 one STOP", nStop, 1);
    if (expRx > 0)
      chk(stopCyc > lastRxCyc, "R6 STOP after last byte", stopCyc, lastRxCyc + 1);
    chk(nDone == 1, "R9 single done", nDone, 1);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      nFail++; nChk++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", nFail, nChk);
      $finish;
    end
  end

  initial begin
    vec_t wv;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!done && !err, "R10 done/err after reset", {30'd0, done, err}, 32'd0);
    chk(rdData == 16'h0, "R10 rdData after reset", 32'(rdData), 32'd0);
    chk(!(engStartReq || engStopReq || engTxReq || engRxReq),
        "R10 no request after reset",
        {28'd0, engStartReq, engStopReq, engTxReq, engRxReq}, 32'd0);

    // table walk
    for (int k = 0; k < NumVec; k++) begin
      launch(Vecs[k]);
      waitDone();
      checkVec(Vecs[k]);
    end

    // R2: bus busy holds off the first START
    wv = Vecs[1];
    engBusy = 1'b1;
    launch(wv);
    repeat (8) @(negedge clk);
    begin
      int relCyc;
      relCyc = cyc;
      engBusy = 1'b0;
      waitDone();
      checkVec(wv);
      chk(firstStartCyc > relCyc, "R2 START after bus idle", firstStartCyc, relCyc + 1);
    end

    // R8: bus stays busy past the limit
    engBusy = 1'b1;
    launch(Vecs[0]);
    gotDone = 1'b0;
    for (int i = 0; i < 200 && !gotDone; i++) begin
      @(negedge clk);
      if (done) begin gotDone = 1'b1; gotErr = err; end
    end
    engBusy = 1'b0;
    chk(gotDone && gotErr, "R8 busy wait timeout error", {30'd0, gotDone, gotErr}, 32'd3);
    chk(nStart == 0, "R8 no START on busy timeout", nStart, 0);
    chk(nStop == 1, "R8 STOP on busy timeout", nStop, 1);
    repeat (4) @(negedge clk);

    // R9: start pulse during a running write is ignored
    wv = Vecs[8];
    launch(wv);
    repeat (4) @(posedge clk);
    #1 cmdStart = 1'b1; cmdRead = 1'b1; cmdTwo = 1'b1; cmdSlave = 7'h6B; cmdReg = 8'h99;
    @(posedge clk); #1 cmdStart = 1'b0;
    waitDone();
    checkVec(wv);

    $display("Result: errors=%0d of %0d checks", nFail, nChk);
    $finish;
  end
endmodule